// File: doc/BRIEF.md
# USB Endpoint Stall Control

This block keeps the STALL state of a USB device controller that has one control endpoint (endpoint 0) and five data endpoints (endpoints 1 to 5). The CPU writes a per-endpoint stall request bit. A level input selects whether a host Clear Feature also drops that request bit. The protocol engine supplies single-cycle strobes: a SETUP packet on endpoint 0, an IN or OUT token for endpoint n, and a decoded Set Feature or Clear Feature (endpoint halt) request that names endpoint n.

For every token, the block states in the same cycle whether the handshake must be STALL. Each data endpoint also has a halt flag of its own, apart from the request bit. That flag is latched when a token meets a set request bit, or when the host sends Set Feature. Only Clear Feature or a bus reset removes it. Endpoint 0 works differently: it has no halt flag, and its request bit releases itself when the next SETUP arrives. Both bit vectors are exported so software can read them back.

Top module: `usb_stall_ctl`

## Requirements
- R1: Reset (rstN low) or a busReset pulse clears every request bit and every halt flag. After a busReset pulse, reqBits and haltBits both read 0 on the next cycle.
- R2: A cycle with cpuWrEn high loads cpuWrData into bit cpuWrEp of reqBits on the next edge. A CPU write never changes haltBits. A write to an endpoint number of 6 or 7 changes nothing.
- R3: A token to endpoint 0 gets STALL exactly when reqBits[0] is 1. setupSeen clears reqBits[0] on the next edge, and it wins over a CPU write to endpoint 0 in the same cycle. haltBits[0] always reads 0.
- R4: A token to endpoint n (1 to 5) while reqBits[n] is 1 drives stallOut high in that same cycle. It also sets haltBits[n] on the next edge.
- R5: While haltBits[n] is 1, every token to endpoint n gets stallOut high, whatever reqBits[n] holds.
- R6: A Clear Feature (featValid=1, featSet=0) naming endpoint n with autoClrEn=0 clears haltBits[n] and leaves reqBits[n] unchanged.
- R7: A Clear Feature naming endpoint n with autoClrEn=1 clears haltBits[n] and reqBits[n] on the same edge. This clear wins over a CPU write to endpoint n in that cycle.
- R8: A Set Feature (featValid=1, featSet=1) naming endpoint n (1 to 5) sets haltBits[n] whatever reqBits[n] holds.
- R9: Set Feature and Clear Feature naming endpoint 0, 6 or 7 leave all halt flags and request bits unchanged. Tokens to endpoint 6 or 7 never get STALL.
- R10: stallOut is 0 in every cycle where tokValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReset | input | 1 | USB bus reset strobe |
| autoClrEn | input | 1 | Clear Feature also drops the request bit |
| cpuWrEn | input | 1 | CPU write strobe for a request bit |
| cpuWrEp | input | 3 | Endpoint number of the CPU write |
| cpuWrData | input | 1 | Value written to the request bit |
| setupSeen | input | 1 | SETUP packet detected on endpoint 0 |
| tokValid | input | 1 | IN/OUT token strobe |
| tokEp | input | 3 | Endpoint number of the token |
| featValid | input | 1 | Decoded endpoint-halt feature request strobe |
| featSet | input | 1 | 1 = Set Feature, 0 = Clear Feature |
| featEp | input | 3 | Endpoint named by the feature request |
| stallOut | output | 1 | Answer the current token with STALL |
| reqBits | output | 6 | Stall request bits, bit n = endpoint n |
| haltBits | output | 6 | Halt flags, bit n = endpoint n (bit 0 always 0) |

## Verification
The assertions check, on every cycle, the relations that span one edge. These are: a token that meets a set request latches the halt flag; a halt flag survives anything except Clear Feature or bus reset; SETUP drops the endpoint 0 request; auto-clear drops both bits; Set Feature sets the flag. They also check that a set flag always yields STALL and that no STALL appears without a token. Only the bench scenarios can show the longer sequences. Examples are the flag re-latching after a Clear Feature while the request stays set, and a request cleared by software that still stalls until the host releases it. The bench also covers same-cycle races between CPU writes and hardware clears, and requests naming endpoints 0, 6 and 7 against a reference model.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;
  parameter int EP_COUNT  = 6;
  parameter int EP_IDX_W  = 3;

  // Per-endpoint strobes from the control decode to the state registers.
  typedef struct packed {
    logic [EP_COUNT-1:0] tokHit;
    logic [EP_COUNT-1:0] wrHit;
    logic [EP_COUNT-1:0] reqClr;
    logic [EP_COUNT-1:0] haltSet;
    logic [EP_COUNT-1:0] haltClr;
    logic                wrVal;
  } stall_strobe_t;
endpackage

// File: rtl/usb_stall_ctrl.sv
module usb_stall_ctrl
  import usb_stall_pkg::*;
(
  input  logic                busReset,
  input  logic                autoClrEn,
  input  logic                cpuWrEn,
  input  logic [EP_IDX_W-1:0] cpuWrEp,
  input  logic                cpuWrData,
  input  logic                setupSeen,
  input  logic                tokValid,
  input  logic [EP_IDX_W-1:0] tokEp,
  input  logic                featValid,
  input  logic                featSet,
  input  logic [EP_IDX_W-1:0] featEp,
  input  logic [EP_COUNT-1:0] reqBits,
  output stall_strobe_t       strobes
);
  logic [EP_COUNT-1:0] tokHit, wrHit, reqClr, haltSet, haltClr;

  for (genvar n = 0; n < EP_COUNT; n++) begin : g_ep
    localparam logic [EP_IDX_W-1:0] EP_ID = EP_IDX_W'(n);
    assign tokHit[n] = tokValid && (tokEp == EP_ID);
    assign wrHit[n]  = cpuWrEn && (cpuWrEp == EP_ID);
    if (n == 0) begin : g_ctl
      // control endpoint: SETUP releases the request, no halt flag
      assign reqClr[n]  = busReset || setupSeen;
      assign haltSet[n] = 1'b0;
      assign haltClr[n] = 1'b0;
    end else begin : g_data
      logic featHit;
      assign featHit    = featValid && (featEp == EP_ID);
      assign reqClr[n]  = busReset || (featHit && !featSet && autoClrEn);
      assign haltClr[n] = busReset || (featHit && !featSet);
      assign haltSet[n] = (featHit && featSet) || (tokHit[n] && reqBits[n]);
    end
  end

  always_comb begin
    strobes.tokHit  = tokHit;
    strobes.wrHit   = wrHit;
    strobes.reqClr  = reqClr;
    strobes.haltSet = haltSet;
    strobes.haltClr = haltClr;
    strobes.wrVal   = cpuWrData;
  end
endmodule

// File: rtl/usb_stall_dp.sv
module usb_stall_dp
  import usb_stall_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stall_strobe_t       strobes,
  output logic                stallOut,
  output logic [EP_COUNT-1:0] reqBits,
  output logic [EP_COUNT-1:0] haltBits
);
  for (genvar n = 0; n < EP_COUNT; n++) begin : g_ep
    // hardware clear ranks above the CPU write
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  reqBits[n] <= 1'b0;
      else if (strobes.reqClr[n]) reqBits[n] <= 1'b0;
      else if (strobes.wrHit[n])  reqBits[n] <= strobes.wrVal;
    end
    if (n == 0) begin : g_nohalt
      assign haltBits[n] = 1'b0;
    end else begin : g_halt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    haltBits[n] <= 1'b0;
        else if (strobes.haltClr[n])  haltBits[n] <= 1'b0;
        else if (strobes.haltSet[n])  haltBits[n] <= 1'b1;
      end
    end
  end

  // decision uses pre-edge state so first and later tokens match
  assign stallOut = |(strobes.tokHit & (reqBits | haltBits));
endmodule

// File: rtl/usb_stall_ctl.sv
module usb_stall_ctl
  import usb_stall_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReset,
  input  logic                autoClrEn,
  input  logic                cpuWrEn,
  input  logic [EP_IDX_W-1:0] cpuWrEp,
  input  logic                cpuWrData,
  input  logic                setupSeen,
  input  logic                tokValid,
  input  logic [EP_IDX_W-1:0] tokEp,
  input  logic                featValid,
  input  logic                featSet,
  input  logic [EP_IDX_W-1:0] featEp,
  output logic                stallOut,
  output logic [EP_COUNT-1:0] reqBits,
  output logic [EP_COUNT-1:0] haltBits
);
  stall_strobe_t strobes;

  usb_stall_ctrl u_ctrl (
    .busReset (busReset),
    .autoClrEn(autoClrEn),
    .cpuWrEn  (cpuWrEn),
    .cpuWrEp  (cpuWrEp),
    .cpuWrData(cpuWrData),
    .setupSeen(setupSeen),
    .tokValid (tokValid),
    .tokEp    (tokEp),
    .featValid(featValid),
    .featSet  (featSet),
    .featEp   (featEp),
    .reqBits  (reqBits),
    .strobes  (strobes)
  );

  usb_stall_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .stallOut(stallOut),
    .reqBits (reqBits),
    .haltBits(haltBits)
  );
endmodule

// File: rtl/usb_stall_chk.sv
module usb_stall_chk
  import usb_stall_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                busReset,
  input logic                autoClrEn,
  input logic                setupSeen,
  input logic                tokValid,
  input logic [EP_IDX_W-1:0] tokEp,
  input logic                featValid,
  input logic                featSet,
  input logic [EP_IDX_W-1:0] featEp,
  input logic                stallOut,
  input logic [EP_COUNT-1:0] reqBits,
  input logic [EP_COUNT-1:0] haltBits
);
  AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (reqBits == '0) && (haltBits == '0)); // R1

  AST_SETUP_DROPS_EP0: assert property (@(posedge clk) disable iff (!rstN)
    setupSeen |=> !reqBits[0]); // R3

  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !tokValid |-> !stallOut); // R10

  for (genvar n = 1; n < EP_COUNT; n++) begin : g_ep
    localparam logic [EP_IDX_W-1:0] EP_ID = EP_IDX_W'(n);

    AST_TOKEN_LATCHES_HALT: assert property (@(posedge clk) disable iff (!rstN)
      (tokValid && tokEp == EP_ID && reqBits[n] && !busReset &&
       !(featValid && !featSet && featEp == EP_ID)) |=> haltBits[n]); // R4

    AST_HALT_STALLS: assert property (@(posedge clk) disable iff (!rstN)
      (tokValid && tokEp == EP_ID && haltBits[n]) |-> stallOut); // R5

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (haltBits[n] && !busReset && !(featValid && !featSet && featEp == EP_ID))
      |=> haltBits[n]); // R5

    AST_AUTO_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rstN)
      (featValid && !featSet && featEp == EP_ID && autoClrEn)
      |=> !reqBits[n] && !haltBits[n]); // R7

    AST_SET_FEATURE_HALTS: assert property (@(posedge clk) disable iff (!rstN)
      (featValid && featSet && featEp == EP_ID && !busReset) |=> haltBits[n]); // R8
  end
endmodule

bind usb_stall_ctl usb_stall_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReset (busReset),
  .autoClrEn(autoClrEn),
  .setupSeen(setupSeen),
  .tokValid (tokValid),
  .tokEp    (tokEp),
  .featValid(featValid),
  .featSet  (featSet),
  .featEp   (featEp),
  .stallOut (stallOut),
  .reqBits  (reqBits),
  .haltBits (haltBits)
);

// File: tb/sim_usb_stall_ctl.sv
`timescale 1ns/1ps
module sim_usb_stall_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 0, autoClrEn = 0, cpuWrEn = 0, cpuWrData = 0;
  logic setupSeen = 0, tokValid = 0, featValid = 0, featSet = 0;
  logic [2:0] cpuWrEp = 0, tokEp = 0, featEp = 0;
  logic stallOut;
  logic [5:0] reqBits, haltBits;
  logic [5:0] mReq = 0, mHalt = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usb_stall_ctl u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .autoClrEn(autoClrEn),
    .cpuWrEn(cpuWrEn), .cpuWrEp(cpuWrEp), .cpuWrData(cpuWrData),
    .setupSeen(setupSeen), .tokValid(tokValid), .tokEp(tokEp),
    .featValid(featValid), .featSet(featSet), .featEp(featEp),
    .stallOut(stallOut), .reqBits(reqBits), .haltBits(haltBits)
  );

  function automatic logic expStall();
    if (!tokValid || tokEp > 3'd5) return 1'b0;
    return mReq[tokEp] | mHalt[tokEp];
  endfunction

  // reference model of one clock edge, written from the requirements
  task automatic modelEdge();
    logic [5:0] nReq = mReq, nHalt = mHalt;
    if (busReset) begin nReq = '0; nHalt = '0; end
    else begin
      if (cpuWrEn && cpuWrEp <= 3'd5) nReq[cpuWrEp] = cpuWrData;
      if (tokValid && tokEp >= 3'd1 && tokEp <= 3'd5 && mReq[tokEp]) nHalt[tokEp] = 1'b1;
      if (featValid && featEp >= 3'd1 && featEp <= 3'd5) begin
        if (featSet) nHalt[featEp] = 1'b1;
        else begin
          nHalt[featEp] = 1'b0;
          if (autoClrEn) nReq[featEp] = 1'b0;
        end
      end
      if (setupSeen) nReq[0] = 1'b0;
    end
    mReq = nReq; mHalt = nHalt;
  endtask

  task automatic check(string tag, string what, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // called at a negative edge: drive, check stall, clock, check state
  task automatic step(string tag, logic br, logic ac, logic we, logic [2:0] wep,
                      logic wd, logic su, logic tv, logic [2:0] tep,
                      logic fv, logic fs, logic [2:0] fep);
    busReset = br; autoClrEn = ac; cpuWrEn = we; cpuWrEp = wep; cpuWrData = wd;
    setupSeen = su; tokValid = tv; tokEp = tep; featValid = fv; featSet = fs; featEp = fep;
    #1;
    check(tag, "stallOut", {5'd0, stallOut}, {5'd0, expStall()});
    modelEdge();
    @(posedge clk); #1;
    check(tag, "reqBits", reqBits, mReq);
    check(tag, "haltBits", haltBits, mHalt);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5A17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", "reqBits after reset", reqBits, 6'd0);
    check("R1", "haltBits after reset", haltBits, 6'd0);
    rstN = 1'b1;
    @(negedge clk);
    //          tag  br ac we wep wd su tv tep fv fs fep
    step("R2", 0, 0, 1, 3'd0, 1, 0, 0, 3'd0, 0, 0, 3'd0);
    step("R3", 0, 0, 0, 3'd0, 0, 0, 1, 3'd0, 0, 0, 3'd0);   // EP0 token stalls
    step("R3", 0, 0, 1, 3'd0, 1, 1, 0, 3'd0, 0, 0, 3'd0);   // SETUP beats write
    step("R3", 0, 0, 0, 3'd0, 0, 0, 1, 3'd0, 0, 0, 3'd0);   // released
    step("R2", 0, 0, 1, 3'd2, 1, 0, 0, 3'd0, 0, 0, 3'd0);   // halt untouched
    step("R4", 0, 0, 0, 3'd0, 0, 0, 1, 3'd2, 0, 0, 3'd0);
    step("R5", 0, 0, 1, 3'd2, 0, 0, 0, 3'd0, 0, 0, 3'd0);
    step("R5", 0, 0, 0, 3'd0, 0, 0, 1, 3'd2, 0, 0, 3'd0);
    step("R6", 0, 0, 1, 3'd2, 1, 0, 0, 3'd0, 0, 0, 3'd0);
    step("R6", 0, 0, 0, 3'd0, 0, 0, 0, 3'd0, 1, 0, 3'd2);
    step("R6", 0, 0, 0, 3'd0, 0, 0, 1, 3'd2, 0, 0, 3'd0);   // relatches
    step("R7", 0, 1, 1, 3'd2, 1, 0, 0, 3'd0, 1, 0, 3'd2);   // clear beats write
    step("R7", 0, 1, 0, 3'd0, 0, 0, 1, 3'd2, 0, 0, 3'd0);   // not stalled
    step("R8", 0, 0, 0, 3'd0, 0, 0, 0, 3'd0, 1, 1, 3'd4);
    step("R8", 0, 0, 0, 3'd0, 0, 0, 1, 3'd4, 0, 0, 3'd0);
    step("R9", 0, 0, 0, 3'd0, 0, 0, 0, 3'd0, 1, 1, 3'd0);
    step("R9", 0, 0, 0, 3'd0, 0, 0, 0, 3'd0, 1, 0, 3'd7);
    step("R9", 0, 0, 0, 3'd0, 0, 0, 1, 3'd7, 0, 0, 3'd0);
    step("R2", 0, 0, 1, 3'd6, 1, 0, 0, 3'd0, 0, 0, 3'd0);
    step("R10", 0, 0, 0, 3'd0, 0, 0, 0, 3'd4, 0, 0, 3'd0);
    step("R1", 1, 0, 0, 3'd0, 0, 0, 0, 3'd0, 0, 0, 3'd0);
    for (int i = 0; i < 4000; i++) begin
      step("R2/R4/R5/R6/R7/R8",
           ($urandom % 64) == 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0, 3'($urandom), 1'($urandom),
           ($urandom % 12) == 0, ($urandom % 2) == 0, 3'($urandom),
           ($urandom % 6) == 0, 1'($urandom), 3'($urandom));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule